// File: doc/BRIEF.md
# Sprite Fetch Sequencer with Bus Capture

This block runs the sprite side of a tile-and-sprite video generator's memory schedule for eight sprites. The generator splits each system clock into a video half and a CPU half. The block receives one clock edge per half-cycle, together with the current raster cycle and line. Each sprite owns two consecutive cycles in the line. The slots follow sprite-number order and wrap past the end of the line.

In its slot a sprite always reads its pointer byte, and it always writes its three-byte data buffer. While sprite DMA is on, the three bytes come from memory at pointer times 64 plus a per-sprite row counter. While DMA is off, the video half still makes an idle read of the last bank address. The two CPU halves then capture whatever byte sits on the chip's internal bus. That byte is 0xFF unless a register access is driving it.

DMA is switched on late in the line. A sprite placed far enough to the right can therefore start displaying on its Y-match line, using buffer contents that were captured before its DMA began.

Top module: `sprfetch_top`

## Requirements
- R1: While rst_ni is low, disp_o and buf_o are all zero.
- R2: Sprite s owns cycles (58+2s) mod 63 and the cycle after it. In the video half (phase_i=0) of its first cycle, mem_rd_o is 1 and addr_o is 0x07F8+s. The byte read there becomes the sprite's pointer. This happens on every line, whether DMA is on or off.
- R3: At the end of the CPU half of cycle 57, DMA starts with row counter 0 for each sprite that has DMA off, its enable bit high, and a Y value (zero-extended) equal to line_i. A disabled sprite never starts DMA.
- R4: With DMA on, three reads fill the buffer. Byte 0 is read in the CPU half of the first slot cycle, at address {pointer, counter}. Byte 1 is read in the video half of the second cycle, at counter+1. Byte 2 is read in the CPU half of the second cycle, at counter+2. Each read raises mem_rd_o. Sprite s's buffer is buf_o[24s+23:24s], with byte 0 in the top 8 bits and byte 2 in the bottom 8 bits.
- R5: With DMA off, byte 1 is loaded from an idle read at address 0x3FFF. Bytes 0 and 2 are loaded from the internal bus value of their CPU halves.
- R6: In a CPU half, the internal bus value is cpu_data_i when reg_acc_i is 1, and 0xFF otherwise. A CPU half with no active DMA makes no memory read (mem_rd_o is 0).
- R7: A sprite whose DMA started on line N with X below 0x164 raises disp_o from cycle 0 of line N+1.
- R8: A sprite whose DMA starts with X of 0x164 or greater raises disp_o from cycle 58 of that same line.
- R9: In the CPU half of cycle 11, each active sprite's row counter grows by 3. If the counter was already 60, DMA and disp_o drop instead, so each sprite gets 21 rows.
- R10: Sprite 0's slot follows the DMA switch-on, so on its Y-match line its buffer already holds memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle clock, one edge per half |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_i | input | 6 | Raster cycle within the line, 0 to 62 |
| line_i | input | 9 | Raster line number |
| phase_i | input | 1 | 0 = video half, 1 = CPU half |
| spr_en_i | input | 8 | Sprite enable bits |
| spr_y_i | input | 64 | Y registers, sprite s at [8s+7:8s] |
| spr_x_i | input | 72 | X registers, sprite s at [9s+8:9s] |
| reg_acc_i | input | 1 | CPU register access in this CPU half |
| cpu_data_i | input | 8 | Byte the CPU access puts on the internal bus |
| mem_data_i | input | 8 | Memory read data for addr_o |
| addr_o | output | 14 | Fetch address |
| mem_rd_o | output | 1 | Memory read in this half-cycle |
| disp_o | output | 8 | Per-sprite display-active flags |
| buf_o | output | 192 | Per-sprite three-byte data buffers |

## Verification
The bench places sprite 3 far right on its Y-match line and checks the bytes it captures before DMA starts. A design that read memory in place of the bus would show pointer data, and one that ignored the idle read would leave the middle byte wrong. Two separate register-access bytes are driven into one sprite's two CPU halves. A swapped byte order or a stale bus latch shows up there. A disabled sprite is checked for pulled-up 0xFF capture and no display. A normally placed sprite is checked for display one line late, for its counter step, and for a cut-off after exactly 21 rows. An off-by-one row count would keep it visible, or drop it, one line off.

// File: rtl/sprfetch_pkg.sv
package sprfetch_pkg;
  localparam int unsigned DATA_W = 8;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    byte_t b0;
    byte_t b1;
    byte_t b2;
  } spr_buf_t;

  // encoding is {second_cycle, cpu_half}
  typedef enum logic [1:0] {
    ST_PTR = 2'b00,
    ST_B0  = 2'b01,
    ST_B1  = 2'b10,
    ST_B2  = 2'b11
  } slot_step_e;
endpackage

// File: rtl/sprfetch_slot_dec.sv
module sprfetch_slot_dec
  import sprfetch_pkg::*;
#(
  parameter int unsigned LINE_CYC  = 63,
  parameter int unsigned SLOT0_CYC = 58,
  parameter int unsigned NUM_SPR   = 8,
  localparam int unsigned CW = $clog2(LINE_CYC),
  localparam int unsigned SW = $clog2(NUM_SPR)
) (
  input  logic [CW-1:0] cycle_i,
  input  logic          phase_i,
  output logic          slot_vld_o,
  output logic [SW-1:0] slot_id_o,
  output slot_step_e    step_o
);
  int rel;

  always_comb begin
    if (int'(cycle_i) >= int'(SLOT0_CYC)) rel = int'(cycle_i) - int'(SLOT0_CYC);
    else rel = int'(cycle_i) + int'(LINE_CYC) - int'(SLOT0_CYC);
    slot_vld_o = rel < int'(2 * NUM_SPR);
    slot_id_o  = SW'(rel >> 1);
    step_o     = slot_step_e'({rel[0], phase_i});
  end
endmodule

// File: rtl/sprfetch_sprite.sv
module sprfetch_sprite
  import sprfetch_pkg::*;
#(
  parameter int unsigned PTR_W    = 8,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned CNT_STEP = 3,
  parameter int unsigned LAST_CNT = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  slot_step_e       step_i,
  input  logic             dma_chk_i,
  input  logic             cnt_upd_i,
  input  logic             line_end_i,
  input  logic             start_i,
  input  logic             early_i,
  input  byte_t            bus_i,
  input  byte_t            mem_i,
  output logic             dma_o,
  output logic             disp_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output spr_buf_t         buf_o
);
  logic             dma_q, disp_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  spr_buf_t         buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q  <= 1'b0;
      disp_q <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
    end else begin
      if (sel_i) begin
        unique case (step_i)
          ST_PTR: ptr_q    <= PTR_W'(mem_i);
          ST_B0:  buf_q.b0 <= dma_q ? mem_i : bus_i;
          ST_B1:  buf_q.b1 <= mem_i;  // data or idle read, chosen by the address mux
          ST_B2:  buf_q.b2 <= dma_q ? mem_i : bus_i;
          default: ;
        endcase
      end
      if (dma_chk_i && !dma_q && start_i) begin
        dma_q <= 1'b1;
        cnt_q <= '0;
        if (early_i) disp_q <= 1'b1;
      end
      if (cnt_upd_i && dma_q) begin
        if (cnt_q == CNT_W'(LAST_CNT)) begin
          dma_q  <= 1'b0;
          disp_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(CNT_STEP);
        end
      end
      if (line_end_i && dma_q) disp_q <= 1'b1;
    end
  end

  assign dma_o  = dma_q;
  assign disp_o = disp_q;
  assign ptr_o  = ptr_q;
  assign cnt_o  = cnt_q;
  assign buf_o  = buf_q;
endmodule

// File: rtl/sprfetch_top.sv
module sprfetch_top
  import sprfetch_pkg::*;
#(
  parameter int unsigned NUM_SPR   = 8,
  parameter int unsigned LINE_CYC  = 63,
  parameter int unsigned SLOT0_CYC = 58,
  parameter int unsigned DMA_CYC   = 57,
  parameter int unsigned ROWS      = 21,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned Y_W       = 8,
  parameter int unsigned X_W       = 9,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned CNT_W     = 6,
  parameter logic [8:0]  EARLY_X   = 9'h164,
  parameter logic [13:0] PTR_BASE  = 14'h07F8,
  parameter logic [13:0] IDLE_ADDR = 14'h3FFF,
  localparam int unsigned CW       = $clog2(LINE_CYC),
  localparam int unsigned SW       = $clog2(NUM_SPR),
  localparam int unsigned PTR_W    = ADDR_W - CNT_W,
  localparam int unsigned CNT_CYC  = (SLOT0_CYC + 2 * NUM_SPR) % LINE_CYC,
  localparam int unsigned LAST_CNT = 3 * (ROWS - 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CW-1:0]             cycle_i,
  input  logic [LINE_W-1:0]         line_i,
  input  logic                      phase_i,
  input  logic [NUM_SPR-1:0]        spr_en_i,
  input  logic [NUM_SPR*Y_W-1:0]    spr_y_i,
  input  logic [NUM_SPR*X_W-1:0]    spr_x_i,
  input  logic                      reg_acc_i,
  input  logic [DATA_W-1:0]         cpu_data_i,
  input  logic [DATA_W-1:0]         mem_data_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      mem_rd_o,
  output logic [NUM_SPR-1:0]        disp_o,
  output logic [NUM_SPR*24-1:0]     buf_o
);
  logic          slot_vld;
  logic [SW-1:0] slot_id;
  slot_step_e    step;
  byte_t         bus_val;
  logic          dma_chk, cnt_upd, line_end;

  logic [NUM_SPR-1:0] dma_w;
  logic [PTR_W-1:0]   ptr_w [NUM_SPR];
  logic [CNT_W-1:0]   cnt_w [NUM_SPR];
  spr_buf_t           buf_w [NUM_SPR];

  sprfetch_slot_dec #(
    .LINE_CYC (LINE_CYC),
    .SLOT0_CYC(SLOT0_CYC),
    .NUM_SPR  (NUM_SPR)
  ) i_slot_dec (
    .cycle_i   (cycle_i),
    .phase_i   (phase_i),
    .slot_vld_o(slot_vld),
    .slot_id_o (slot_id),
    .step_o    (step)
  );

  // undriven internal bus is pulled up
  assign bus_val  = reg_acc_i ? cpu_data_i : 8'hFF;
  assign dma_chk  = phase_i && (cycle_i == CW'(DMA_CYC));
  assign cnt_upd  = phase_i && (cycle_i == CW'(CNT_CYC));
  assign line_end = phase_i && (cycle_i == CW'(LINE_CYC - 1));

  for (genvar s = 0; s < NUM_SPR; s++) begin : g_spr
    logic start, early;
    assign start = spr_en_i[s] && (line_i == LINE_W'(spr_y_i[s*Y_W +: Y_W]));
    assign early = spr_x_i[s*X_W +: X_W] >= X_W'(EARLY_X);

    sprfetch_sprite #(
      .PTR_W   (PTR_W),
      .CNT_W   (CNT_W),
      .CNT_STEP(3),
      .LAST_CNT(LAST_CNT)
    ) i_sprite (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (slot_vld && (slot_id == SW'(s))),
      .step_i    (step),
      .dma_chk_i (dma_chk),
      .cnt_upd_i (cnt_upd),
      .line_end_i(line_end),
      .start_i   (start),
      .early_i   (early),
      .bus_i     (bus_val),
      .mem_i     (mem_data_i),
      .dma_o     (dma_w[s]),
      .disp_o    (disp_o[s]),
      .ptr_o     (ptr_w[s]),
      .cnt_o     (cnt_w[s]),
      .buf_o     (buf_w[s])
    );

    assign buf_o[s*24 +: 24] = buf_w[s];
  end

  logic             dma_sel;
  logic [PTR_W-1:0] ptr_sel;
  logic [CNT_W-1:0] cnt_sel;

  assign dma_sel = dma_w[slot_id];
  assign ptr_sel = ptr_w[slot_id];
  assign cnt_sel = cnt_w[slot_id];

  always_comb begin
    addr_o   = IDLE_ADDR;
    mem_rd_o = 1'b0;
    if (slot_vld) begin
      unique case (step)
        ST_PTR: begin
          addr_o   = PTR_BASE + ADDR_W'(slot_id);
          mem_rd_o = 1'b1;
        end
        ST_B0: if (dma_sel) begin
          addr_o   = {ptr_sel, cnt_sel};
          mem_rd_o = 1'b1;
        end
        ST_B1: begin
          mem_rd_o = 1'b1;
          if (dma_sel) addr_o = {ptr_sel, cnt_sel + CNT_W'(1)};
        end
        ST_B2: if (dma_sel) begin
          addr_o   = {ptr_sel, cnt_sel + CNT_W'(2)};
          mem_rd_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sprfetch_chk.sv
module sprfetch_chk #(
  parameter int unsigned NUM_SPR   = 8,
  parameter int unsigned LINE_CYC  = 63,
  parameter int unsigned SLOT0_CYC = 58,
  parameter int unsigned DMA_CYC   = 57,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned Y_W       = 8,
  parameter int unsigned X_W       = 9,
  parameter logic [8:0]  EARLY_X   = 9'h164,
  localparam int unsigned CW       = $clog2(LINE_CYC),
  localparam int unsigned END_CYC  = (SLOT0_CYC + 2 * NUM_SPR - 1) % LINE_CYC
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CW-1:0]          cycle_i,
  input logic [LINE_W-1:0]      line_i,
  input logic                   phase_i,
  input logic [NUM_SPR-1:0]     spr_en_i,
  input logic [NUM_SPR*Y_W-1:0] spr_y_i,
  input logic [NUM_SPR*X_W-1:0] spr_x_i,
  input logic                   mem_rd_o,
  input logic [NUM_SPR-1:0]     disp_o,
  input logic [NUM_SPR-1:0]     dma_w
);
  // R2: every video half inside the slot window reads memory
  a_r2_video_slot_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_i && (int'(cycle_i) >= int'(SLOT0_CYC) || int'(cycle_i) <= int'(END_CYC)))
      |-> mem_rd_o);

  // R6: CPU halves stay off memory when no sprite has DMA
  a_r6_cpu_half_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && (dma_w == '0)) |-> !mem_rd_o);

  // R9: display never outlives DMA
  a_r9_disp_within_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_o & ~dma_w) == '0);

  for (genvar s = 0; s < NUM_SPR; s++) begin : g_chk
    a_r3_disabled_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!spr_en_i[s] && !dma_w[s]) |=> !dma_w[s]);

    a_r8_same_line_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_i && cycle_i == CW'(DMA_CYC) && spr_en_i[s] && !dma_w[s]
        && line_i == LINE_W'(spr_y_i[s*Y_W +: Y_W])
        && spr_x_i[s*X_W +: X_W] >= X_W'(EARLY_X)) |=> disp_o[s]);
  end
endmodule

bind sprfetch_top sprfetch_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cycle_i (cycle_i),
  .line_i  (line_i),
  .phase_i (phase_i),
  .spr_en_i(spr_en_i),
  .spr_y_i (spr_y_i),
  .spr_x_i (spr_x_i),
  .mem_rd_o(mem_rd_o),
  .disp_o  (disp_o),
  .dma_w   (dma_w)
);

// File: tb/test_sprfetch_top.sv
module test_sprfetch_top;
  localparam int L = 'h32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [5:0]   cyc;
  logic [8:0]   line;
  logic         ph;
  logic [7:0]   en;
  logic [63:0]  ys;
  logic [71:0]  xs;
  logic         reg_acc;
  logic [7:0]   cpu_data;
  logic [7:0]   mem_data;
  logic [13:0]  addr;
  logic         mem_rd;
  logic [7:0]   disp;
  logic [191:0] bufs;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  sprfetch_top i_sprfetch_top (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cyc), .line_i(line), .phase_i(ph),
    .spr_en_i(en), .spr_y_i(ys), .spr_x_i(xs), .reg_acc_i(reg_acc),
    .cpu_data_i(cpu_data), .mem_data_i(mem_data), .addr_o(addr),
    .mem_rd_o(mem_rd), .disp_o(disp), .buf_o(bufs)
  );

  function automatic logic [7:0] memf(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], a[13:12]} ^ 8'h3C;
  endfunction

  always_comb mem_data = memf(addr);

  function automatic logic [23:0] row(input int s, input int cnt);
    logic [7:0]  p;
    logic [13:0] base;
    p    = memf(14'h07F8 + 14'(s));
    base = {p, 6'(cnt)};
    return {memf(base), memf(base + 14'd1), memf(base + 14'd2)};
  endfunction

  function automatic logic [23:0] bof(input int s);
    return bufs[s*24 +: 24];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    #1;
    reg_acc  = 1'b0;
    cpu_data = 8'h00;
    if (ph) begin
      ph = 1'b0;
      if (cyc == 6'd62) begin cyc = 6'd0; line = line + 9'd1; end
      else cyc = cyc + 6'd1;
    end else ph = 1'b1;
    #1;
  endtask

  task automatic goto(input int l, input int c, input int p);
    while (!(int'(line) == l && int'(cyc) == c && int'(ph) == p)) adv();
  endtask

  task automatic t_reset();
    chk("R1 disp", 32'(disp), 32'h0);
    chk("R1 buf3", 32'(bof(3)), 32'h0);
  endtask

  task automatic t_capture_sprite3();
    goto(L, 1, 0);
    chk("R2 ptr addr", 32'(addr), 32'h07FB);
    chk("R2 ptr rd", 32'(mem_rd), 32'h1);
    goto(L, 1, 1);
    chk("R6 no rd in cpu half", 32'(mem_rd), 32'h0);
    reg_acc = 1'b1; cpu_data = 8'h12;
    goto(L, 2, 0);
    chk("R5 idle addr", 32'(addr), 32'h3FFF);
    goto(L, 3, 0);
    chk("R5 sprite3 capture", 32'(bof(3)), 32'({8'h12, memf(14'h3FFF), 8'hFF}));
  endtask

  task automatic t_disabled_sprite5();
    goto(L, 7, 0);
    chk("R6 sprite5 pulled up", 32'(bof(5)), 32'({8'hFF, memf(14'h3FFF), 8'hFF}));
  endtask

  task automatic t_two_bytes_sprite6();
    goto(L, 7, 1);
    reg_acc = 1'b1; cpu_data = 8'hA5;
    goto(L, 8, 1);
    reg_acc = 1'b1; cpu_data = 8'h3C;
    goto(L, 9, 0);
    chk("R5 sprite6 two bus bytes", 32'(bof(6)), 32'({8'hA5, memf(14'h3FFF), 8'h3C}));
  endtask

  task automatic t_same_line();
    goto(L, 57, 1);
    chk("R8 sprite3 not yet", 32'(disp[3]), 32'h0);
    goto(L, 58, 0);
    chk("R8 sprite3 same line", 32'(disp[3]), 32'h1);
    chk("R7 sprite4 waits", 32'(disp[4]), 32'h0);
    goto(L, 60, 0);
    chk("R10 sprite0 real data", 32'(bof(0)), 32'(row(0, 0)));
  endtask

  task automatic t_next_line();
    goto(L + 1, 0, 0);
    chk("R7 sprite4 next line", 32'(disp[4]), 32'h1);
    chk("R3 sprite5 disabled", 32'(disp[5]), 32'h0);
    chk("R3 sprite6 no match", 32'(disp[6]), 32'h0);
  endtask

  task automatic t_dma_fetch();
    goto(L + 1, 3, 1);
    chk("R4 byte0 addr", 32'(addr), 32'({memf(14'h07FC), 6'd0}));
    chk("R4 byte0 rd", 32'(mem_rd), 32'h1);
    goto(L + 1, 5, 0);
    chk("R4 sprite4 row0", 32'(bof(4)), 32'(row(4, 0)));
    goto(L + 2, 5, 0);
    chk("R9 sprite4 row1", 32'(bof(4)), 32'(row(4, 3)));
  endtask

  task automatic t_end();
    goto(L + 21, 5, 0);
    chk("R9 sprite4 last row", 32'(bof(4)), 32'(row(4, 60)));
    goto(L + 21, 11, 0);
    chk("R9 sprite4 still shown", 32'(disp[4]), 32'h1);
    goto(L + 21, 12, 0);
    chk("R9 sprite4 ended", 32'(disp[4]), 32'h0);
    chk("R9 sprite3 ended", 32'(disp[3]), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cyc = 6'd0; line = 9'(L - 1); ph = 1'b0;
    reg_acc = 1'b0; cpu_data = 8'h00;
    en = 8'b0101_1001;
    ys = '0; xs = '0;
    ys[0*8 +: 8] = 8'(L); xs[0*9 +: 9] = 9'h100;
    ys[3*8 +: 8] = 8'(L); xs[3*9 +: 9] = 9'h170;
    ys[4*8 +: 8] = 8'(L); xs[4*9 +: 9] = 9'h100;
    ys[5*8 +: 8] = 8'(L); xs[5*9 +: 9] = 9'h170;
    ys[6*8 +: 8] = 8'h90; xs[6*9 +: 9] = 9'h170;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    t_capture_sprite3();
    t_disabled_sprite5();
    t_two_bytes_sprite6();
    t_same_line();
    t_next_line();
    t_dma_fetch();
    t_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule